// File: doc/BRIEF.md
# Cascaded Slice Byte Sequencer

This block decides which of up to four chained arithmetic slices answers the current byte-wide register access. Each slice carries its own copy of the block. Rather than decoding an address, every copy runs a small sequence counter and compares it with a two-bit chip number strapped on its pins. The copy whose counter equals its strap is the selected slice, and only that copy opens its byte lane into the X, Y or Z register named by the register-select lines.

After any clear, the counter holds the index of the most significant fitted slice, which is the device-count field. Each completed data access (the strobe's high-to-low transition while X, Y or Z is selected) lowers the counter by one, modulo four. Successive bytes therefore land in the most significant slice first and move toward the least significant one. This order is the same for reads and writes and for every register, and registers may be visited in any order relative to one another. With four slices the counter wraps back to the first slice after a full pass. With fewer slices it ends on an unfitted index, so software must clear it before starting another pass. A clear comes from a dedicated clear input or from the clear-sequence bit of a control-word write. A clear always beats a step taken in the same cycle.

Top module: `casc_byte_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, the counter holds `dev_count`, so `dev_sel` is high only for `chip_num == dev_count`.
- R2: `dev_sel` is high exactly when `chip_num` equals the sequence counter, for every strap value 0 to 3.
- R3: A data access steps the counter down by one, modulo 4, on the clock edge that first sees `strobe` low after it was high. A data access is a strobe pulse with `reg_sel` at 01 (X), 10 (Y) or 11 (Z).
- R4: A high `seq_clr` sampled on a clock edge loads the counter with `dev_count`, the index of the most significant slice.
- R5: A control write (`ctl_wr` high) with `ctl_clr_seq` high loads the counter with `dev_count`. `ctl_wr` alone, or `ctl_clr_seq` alone, leaves the counter unchanged.
- R6: When a clear and a step fall on the same edge, the clear wins.
- R7: With `dev_count` = 3 (four slices), four data accesses after a clear leave the counter back at 3.
- R8: With `dev_count` below 3, `dev_count`+1 data accesses after a clear leave the counter at 3, an index no fitted slice owns.
- R9: At most one lane enable is high at a time. A lane enable is high only while `strobe` is high and `dev_sel` is high. 01 selects `x_lane_en`, 10 selects `y_lane_en`, 11 selects `z_lane_en`, and 00 selects none.
- R10: A strobe pulse with `reg_sel` = 00 (control register) does not step the counter.
- R11: A strobe held high for several cycles steps the counter exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Access strobe; the access completes on its falling transition |
| reg_sel | input | 2 | Register select: 00 control, 01 X, 10 Y, 11 Z |
| seq_clr | input | 1 | Clear input for the sequence counter |
| ctl_wr | input | 1 | Control-word write qualifier |
| ctl_clr_seq | input | 1 | Clear-sequence bit of the control word |
| dev_count | input | 2 | Number of fitted slices minus one |
| chip_num | input | 2 | Strapped chip number of this slice |
| dev_sel | output | 1 | This slice owns the current access |
| x_lane_en | output | 1 | Byte lane enable into X |
| y_lane_en | output | 1 | Byte lane enable into Y |
| z_lane_en | output | 1 | Byte lane enable into Z |

## Verification
On every cycle, the assertions check the counter's next value against the previous one: a decrement after a step, a reload after a clear (also when a step coincides with it), and no change otherwise. They also check that a strobe edge never produces two steps in a row, and that the lane enables stay one-hot-or-idle and only open while the strobe and the slice select are both high. Only the bench scenarios can show the whole-pass behaviour. These are the walk across every chip number for each device count, the wrap after four slices against the stranded index for fewer slices, and the cases a control-register access or a lone control bit must leave alone.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;
    localparam int SLOT_W = 2;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'b00,
        SEL_X    = 2'b01,
        SEL_Y    = 2'b10,
        SEL_Z    = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic x_en;
        logic y_en;
        logic z_en;
    } lane_t;

    function automatic logic is_data(reg_sel_e s);
        return s != SEL_CTRL;
    endfunction

    function automatic lane_t lane_of(reg_sel_e s);
        lane_t l;
        l = '0;
        case (s)
            SEL_X:   l.x_en = 1'b1;
            SEL_Y:   l.y_en = 1'b1;
            SEL_Z:   l.z_en = 1'b1;
            default: l = '0;
        endcase
        return l;
    endfunction
endpackage

// File: rtl/cbs_access_edge.sv
`timescale 1ns/1ps
module cbs_access_edge
    import cbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe,
    input  reg_sel_e reg_sel,
    output logic     step
);
    logic     strobe_q;
    reg_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            sel_q    <= SEL_CTRL;
        end else begin
            strobe_q <= strobe;
            sel_q    <= reg_sel;
        end
    end

    // access completes on the strobe's high-to-low transition
    assign step = strobe_q & ~strobe & is_data(sel_q);

    assert_single_step_R11: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
endmodule

// File: rtl/cbs_seq_counter.sv
`timescale 1ns/1ps
module cbs_seq_counter #(
    parameter int W = cbs_pkg::SLOT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seq_clr,
    input  logic         ctl_wr,
    input  logic         ctl_clr_seq,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt
);
    logic clr_any;
    assign clr_any = seq_clr | (ctl_wr & ctl_clr_seq);

    always_ff @(posedge clk) begin
        if (rst || clr_any)
            cnt <= load_val;
        else if (step)
            cnt <= cnt - 1'b1;
    end

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !clr_any) |=> cnt == W'($past(cnt) - 1'b1));
    assert_clear_load_R4: assert property (@(posedge clk) disable iff (rst)
        clr_any |=> cnt == $past(load_val));
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_any && step) |=> cnt == $past(load_val));
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!clr_any && !step) |=> $stable(cnt));
endmodule

// File: rtl/cbs_lane_gate.sv
`timescale 1ns/1ps
module cbs_lane_gate
    import cbs_pkg::*;
(
    input  logic     strobe,
    input  logic     dev_sel,
    input  reg_sel_e reg_sel,
    output lane_t    lanes
);
    always_comb begin
        if (strobe && dev_sel)
            lanes = lane_of(reg_sel);
        else
            lanes = '0;
    end
endmodule

// File: rtl/casc_byte_seq.sv
`timescale 1ns/1ps
module casc_byte_seq
    import cbs_pkg::*;
#(
    parameter int SLOT_W_P = cbs_pkg::SLOT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic                seq_clr,
    input  logic                ctl_wr,
    input  logic                ctl_clr_seq,
    input  logic [SLOT_W_P-1:0] dev_count,
    input  logic [SLOT_W_P-1:0] chip_num,
    output logic                dev_sel,
    output logic                x_lane_en,
    output logic                y_lane_en,
    output logic                z_lane_en
);
    reg_sel_e            sel_e;
    logic                step;
    logic [SLOT_W_P-1:0] cnt;
    lane_t               lanes;

    assign sel_e = reg_sel_e'(reg_sel);

    cbs_access_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .reg_sel (sel_e),
        .step    (step)
    );

    cbs_seq_counter #(.W(SLOT_W_P)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .seq_clr     (seq_clr),
        .ctl_wr      (ctl_wr),
        .ctl_clr_seq (ctl_clr_seq),
        .load_val    (dev_count),
        .step        (step),
        .cnt         (cnt)
    );

    assign dev_sel = (cnt == chip_num);

    cbs_lane_gate u_lane (
        .strobe  (strobe),
        .dev_sel (dev_sel),
        .reg_sel (sel_e),
        .lanes   (lanes)
    );

    assign x_lane_en = lanes.x_en;
    assign y_lane_en = lanes.y_en;
    assign z_lane_en = lanes.z_en;

    assert_lane_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({x_lane_en, y_lane_en, z_lane_en}));
    assert_lane_owner_R9: assert property (@(posedge clk) disable iff (rst)
        (x_lane_en || y_lane_en || z_lane_en) |-> (dev_sel && strobe));
endmodule

// File: tb/tb_casc_byte_seq.sv
`timescale 1ns/1ps
module tb_casc_byte_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0;
    logic [1:0] reg_sel = 2'b00;
    logic       seq_clr = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_clr_seq = 1'b0;
    logic [1:0] dev_count = 2'd2;
    logic [1:0] chip_num = 2'd0;
    logic       dev_sel, x_lane_en, y_lane_en, z_lane_en;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_cnt;

    always #2.5 clk = ~clk;

    casc_byte_seq dut (
        .clk(clk), .rst(rst), .strobe(strobe), .reg_sel(reg_sel),
        .seq_clr(seq_clr), .ctl_wr(ctl_wr), .ctl_clr_seq(ctl_clr_seq),
        .dev_count(dev_count), .chip_num(chip_num), .dev_sel(dev_sel),
        .x_lane_en(x_lane_en), .y_lane_en(y_lane_en), .z_lane_en(z_lane_en)
    );

    // sweep the strap, collect which chip numbers are selected
    task automatic probe_mask(output logic [3:0] mask);
        for (int c = 0; c < 4; c++) begin
            chip_num = 2'(c);
            #0.4;
            mask[c] = dev_sel;
        end
    endtask

    task automatic chk_cnt(input logic [1:0] exp, input string tag);
        logic [3:0] got;
        logic [3:0] want;
        probe_mask(got);
        want = 4'b0001 << exp;
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s select mask got %b expected %b", tag, got, want);
        end
    endtask

    task automatic chk_lanes(input logic [2:0] exp, input string tag);
        checks++;
        if ({x_lane_en, y_lane_en, z_lane_en} !== exp) begin
            errors++;
            $display("FAIL %s lanes got %b expected %b", tag,
                     {x_lane_en, y_lane_en, z_lane_en}, exp);
        end
    endtask

    function automatic logic [2:0] lane_exp(input logic [1:0] s);
        case (s)
            2'b01:   return 3'b100;
            2'b10:   return 3'b010;
            2'b11:   return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    // one strobe pulse of hold cycles; updates the model
    task automatic access(input logic [1:0] s, input int hold, input string tag);
        @(negedge clk);
        strobe = 1'b1; reg_sel = s;
        repeat (hold) @(negedge clk);
        chip_num = m_cnt; #0.4;
        chk_lanes(lane_exp(s), {tag, " R9 owner"});
        chip_num = m_cnt + 2'd1; #0.4;
        chk_lanes(3'b000, {tag, " R9 other"});
        strobe = 1'b0; reg_sel = 2'b00;
        @(negedge clk);
        if (s != 2'b00) m_cnt = m_cnt - 2'd1;
    endtask

    task automatic pulse_clear();
        @(negedge clk); seq_clr = 1'b1;
        @(negedge clk); seq_clr = 1'b0;
        m_cnt = dev_count;
    endtask

    task automatic t_reset();
        dev_count = 2'd2; rst = 1'b1;
        repeat (3) @(negedge clk);
        m_cnt = 2'd2;
        chk_cnt(m_cnt, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        chk_cnt(m_cnt, "R1 after reset");
    endtask

    task automatic t_walk(input logic [1:0] dc);
        dev_count = dc;
        pulse_clear();
        chk_cnt(m_cnt, "R4 clear to most significant");
        for (int i = 0; i <= int'(dc); i++) begin
            access(2'(1 + (i % 3)), 1, "R3 walk");
            chk_cnt(m_cnt, "R2 R3 walk step");
        end
        if (dc == 2'd3) chk_cnt(2'd3, "R7 wrap to first slice");
        else            chk_cnt(2'd3, "R8 stranded after pass");
    endtask

    task automatic t_ctrl();
        dev_count = 2'd3;
        pulse_clear();
        access(2'b01, 1, "R5 prep");
        access(2'b10, 1, "R5 prep");
        @(negedge clk); ctl_wr = 1'b1;
        @(negedge clk); ctl_wr = 1'b0;
        chk_cnt(m_cnt, "R5 ctl_wr alone");
        ctl_clr_seq = 1'b1;
        @(negedge clk); ctl_clr_seq = 1'b0;
        chk_cnt(m_cnt, "R5 clear bit alone");
        ctl_wr = 1'b1; ctl_clr_seq = 1'b1;
        @(negedge clk); ctl_wr = 1'b0; ctl_clr_seq = 1'b0;
        m_cnt = 2'd3;
        chk_cnt(m_cnt, "R5 control clear");
    endtask

    task automatic t_ctrl_access();
        dev_count = 2'd1;
        pulse_clear();
        access(2'b00, 1, "R10 control access");
        chk_cnt(m_cnt, "R10 no step");
    endtask

    task automatic t_priority();
        dev_count = 2'd3;
        pulse_clear();
        access(2'b11, 1, "R6 prep");
        @(negedge clk); strobe = 1'b1; reg_sel = 2'b11;
        @(negedge clk); strobe = 1'b0; reg_sel = 2'b00; seq_clr = 1'b1;
        @(negedge clk); seq_clr = 1'b0;
        m_cnt = 2'd3;
        chk_cnt(m_cnt, "R6 clear beats step");
    endtask

    task automatic t_long();
        dev_count = 2'd2;
        pulse_clear();
        access(2'b10, 5, "R11 long strobe");
        chk_cnt(m_cnt, "R11 single step");
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        for (int d = 0; d < 4; d++) t_walk(2'(d));
        t_ctrl();
        t_ctrl_access();
        t_priority();
        t_long();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule